// File: doc/BRIEF.md
# Prioritized Banked Memory Arbiter

This block sits in front of a banked on-chip memory that several masters share. Four sources can request it. Source 0 is the instruction-cache read miss path. Source 1 is the data-cache miss path, for reads and writes. Source 2 is DMA, for reads and writes. Source 3 covers internal cache maintenance: victim writebacks, line fills and snoops.

The memory takes one access per cycle. An access occupies its bank for two cycles. Each cycle the arbiter looks at the bank each request targets and drops any request whose bank was used in the previous cycle. It then grants the highest-priority request that remains. The granted source's command goes to the memory in the same cycle. Every other requester is stalled and keeps its request stable until it is granted.

Read data comes back a fixed two cycles after the grant. It is tagged with the number of the source that issued the read.

Top module: `membank_arbiter`

## Requirements
- R1: While `rst_n` is low, no source is granted and `mem_en` stays low. After reset no bank is busy and `rd_valid` is low.
- R2: At most one bit of `src_gnt` is set in any cycle. `mem_en` is high exactly when one bit is set.
- R3: Among requests whose bank is free, the lowest source number wins. The order is 0 (instruction fetch), then 1 (data), then 2 (DMA), then 3 (maintenance). A lower-priority request to a different free bank is still not granted in that cycle.
- R4: A bank granted in cycle T is busy in cycle T+1. In T+1, any request to that bank is not granted, while requests to other banks are arbitrated normally. The bank is free again in T+2 unless it was granted again.
- R5: The bank of a request is address bits `[BANK_LSB +: BANK_BITS]`. With the defaults these are bits [5:4], giving four banks.
- R6: `src_stall[i]` is high exactly when `src_req[i]` is high and `src_gnt[i]` is low.
- R7: When `mem_en` is high, `mem_we`, `mem_addr` and `mem_wdata` equal the granted source's `src_we`, address slice and data slice. Source i uses slice `[i*W +: W]` of the packed buses.
- R8: A read granted in cycle T raises `rd_valid` in cycle T+2. In that cycle `rd_src` holds the source number and `rd_data` equals `mem_rdata`. A granted write produces no `rd_valid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_req | input | 4 | Request per source, bit i = source i |
| src_we | input | 4 | Write enable per source (1 = write) |
| src_addr | input | 4*ADDR_W | Packed addresses, source i at [i*ADDR_W +: ADDR_W] |
| src_wdata | input | 4*DATA_W | Packed write data, source i at [i*DATA_W +: DATA_W] |
| src_gnt | output | 4 | One-hot grant |
| src_stall | output | 4 | Request pending but not granted this cycle |
| mem_en | output | 1 | Memory command valid |
| mem_we | output | 1 | Memory command is a write |
| mem_addr | output | ADDR_W | Memory command address |
| mem_wdata | output | DATA_W | Memory command write data |
| mem_rdata | input | DATA_W | Read data from memory, valid two cycles after a read command |
| rd_valid | output | 1 | Returned read data valid |
| rd_src | output | 2 | Source number owning the returned data |
| rd_data | output | DATA_W | Returned read data |

## Verification
A priority decision and a bank-busy stall can land in the same cycle. The highest-priority requester may be blocked by its busy bank, so a lower one must win instead.

The bench provokes this with a one-cycle grant that marks a chosen bank busy. It then drives the next cycle with every combination of request mask and per-source bank. Each expected grant, stall and command is computed in the bench by walking the sources in priority order and skipping the busy bank.

Read returns overlap with these cycles. The bench also judges rd_valid and rd_src against reads it has predicted itself, two cycles earlier.

// File: rtl/membank_pkg.sv
`timescale 1ns/1ps
// Shared constants and types for the banked memory arbiter.
// Assumes exactly four request sources in fixed priority order.
package membank_pkg;
    localparam int NUM_SRC = 4;
    localparam int SRC_W   = 2;

    // Source numbering doubles as priority: lower value wins.
    typedef enum logic [SRC_W-1:0] {
        SRC_IFETCH = 2'd0,
        SRC_DATA   = 2'd1,
        SRC_DMA    = 2'd2,
        SRC_MAINT  = 2'd3
    } src_id_e;
endpackage

// File: rtl/mb_bank_filter.sv
`timescale 1ns/1ps
// Marks each request eligible when the bank it targets is not busy.
// Assumes bank numbers arrive already extracted, BANK_BITS per source.
module mb_bank_filter #(
    parameter int NSRC      = 4,
    parameter int BANK_BITS = 2,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic [NSRC-1:0]           req,
    input  logic [NSRC*BANK_BITS-1:0] bank,
    input  logic [NBANK-1:0]          busy,
    output logic [NSRC-1:0]           elig
);
    for (genvar i = 0; i < NSRC; i++) begin : g_src
        logic [BANK_BITS-1:0] b_i;
        // Pick this source's bank and test it against the busy map.
        assign b_i     = bank[i*BANK_BITS +: BANK_BITS];
        assign elig[i] = req[i] & ~busy[b_i];
    end
endmodule

// File: rtl/mb_prio_pick.sv
`timescale 1ns/1ps
// Fixed-priority one-hot selector; bit 0 has the highest priority.
// Assumes 'allow' low forces no selection (used to hold off grants in reset).
module mb_prio_pick #(
    parameter int N  = 4,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          allow,
    input  logic [N-1:0]  elig,
    output logic [N-1:0]  gnt,
    output logic [IW-1:0] idx,
    output logic          any
);
    // Scan from lowest to highest priority so the last hit (lowest index) wins.
    always_comb begin
        gnt = '0;
        idx = '0;
        any = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            if (allow && elig[i]) begin
                gnt    = '0;
                gnt[i] = 1'b1;
                idx    = IW'(i);
                any    = 1'b1;
            end
        end
    end
endmodule

// File: rtl/mb_busy_track.sv
`timescale 1ns/1ps
// Holds the one-cycle busy map: the bank accessed last cycle is busy now.
// Assumes each access occupies its bank for exactly two cycles.
module mb_busy_track #(
    parameter int BANK_BITS = 2,
    localparam int NBANK    = 1 << BANK_BITS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 take,
    input  logic [BANK_BITS-1:0] bank,
    output logic [NBANK-1:0]     busy
);
    // Record the bank of this cycle's grant for use next cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy <= '0;
        else if (take) busy <= NBANK'(1) << bank;
        else           busy <= '0;
    end
endmodule

// File: rtl/mb_read_return.sv
`timescale 1ns/1ps
// Two-stage tag pipeline that flags returning read data and its owner.
// Assumes memory read data is valid exactly two cycles after the command.
module mb_read_return
    import membank_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             issue,
    input  logic [SRC_W-1:0] src,
    output logic             rd_valid,
    output logic [SRC_W-1:0] rd_src
);
    logic    v1, v2;
    src_id_e s1, s2;

    // Shift the read tag through two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            v1 <= 1'b0;
            v2 <= 1'b0;
            s1 <= SRC_IFETCH;
            s2 <= SRC_IFETCH;
        end else begin
            v1 <= issue;
            s1 <= src_id_e'(src);
            v2 <= v1;
            s2 <= s1;
        end
    end

    assign rd_valid = v2;
    assign rd_src   = s2;
endmodule

// File: rtl/membank_arbiter.sv
`timescale 1ns/1ps
// Arbiter in front of a banked memory with four prioritized sources.
// Grants one request per cycle, stalls requests to a bank used last cycle,
// forwards the granted command and tags read returns by source.
// Assumes requesters hold request, address and data stable while stalled.
module membank_arbiter
    import membank_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 32,
    parameter int BANK_BITS = 2,
    parameter int BANK_LSB  = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [NUM_SRC-1:0]        src_req,
    input  logic [NUM_SRC-1:0]        src_we,
    input  logic [NUM_SRC*ADDR_W-1:0] src_addr,
    input  logic [NUM_SRC*DATA_W-1:0] src_wdata,
    output logic [NUM_SRC-1:0]        src_gnt,
    output logic [NUM_SRC-1:0]        src_stall,
    output logic                      mem_en,
    output logic                      mem_we,
    output logic [ADDR_W-1:0]         mem_addr,
    output logic [DATA_W-1:0]         mem_wdata,
    input  logic [DATA_W-1:0]         mem_rdata,
    output logic                      rd_valid,
    output logic [SRC_W-1:0]          rd_src,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int NBANK = 1 << BANK_BITS;

    logic [NUM_SRC*BANK_BITS-1:0] src_bank;
    logic [NBANK-1:0]             busy;
    logic [NUM_SRC-1:0]           elig;
    logic [SRC_W-1:0]             win_idx;
    logic                         win_any;
    logic [BANK_BITS-1:0]         win_bank;

    // Extract the bank field of every source address.
    for (genvar i = 0; i < NUM_SRC; i++) begin : g_bank
        assign src_bank[i*BANK_BITS +: BANK_BITS] =
            src_addr[i*ADDR_W + BANK_LSB +: BANK_BITS];
    end

    mb_bank_filter #(.NSRC(NUM_SRC), .BANK_BITS(BANK_BITS)) filt_i (
        .req  (src_req),
        .bank (src_bank),
        .busy (busy),
        .elig (elig)
    );

    mb_prio_pick #(.N(NUM_SRC)) pick_i (
        .allow (rst_n),
        .elig  (elig),
        .gnt   (src_gnt),
        .idx   (win_idx),
        .any   (win_any)
    );

    assign win_bank = src_bank[win_idx*BANK_BITS +: BANK_BITS];

    mb_busy_track #(.BANK_BITS(BANK_BITS)) busy_i (
        .clk   (clk),
        .rst_n (rst_n),
        .take  (win_any),
        .bank  (win_bank),
        .busy  (busy)
    );

    // Forward the winning source's command to the memory.
    always_comb begin
        mem_en    = win_any;
        mem_we    = win_any & src_we[win_idx];
        mem_addr  = src_addr[win_idx*ADDR_W +: ADDR_W];
        mem_wdata = src_wdata[win_idx*DATA_W +: DATA_W];
    end

    assign src_stall = src_req & ~src_gnt;

    mb_read_return rr_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .issue    (win_any & ~src_we[win_idx]),
        .src      (win_idx),
        .rd_valid (rd_valid),
        .rd_src   (rd_src)
    );

    assign rd_data = mem_rdata;
endmodule

// File: rtl/membank_arbiter_chk.sv
`timescale 1ns/1ps
// Protocol checker for membank_arbiter, attached by bind.
// Assumes the bank slices are supplied by the bind connections.
module membank_arbiter_chk
    import membank_pkg::*;
#(
    parameter int BANK_BITS = 2
) (
    input logic                         clk,
    input logic                         rst_n,
    input logic [NUM_SRC-1:0]           src_req,
    input logic [NUM_SRC-1:0]           src_gnt,
    input logic [NUM_SRC*BANK_BITS-1:0] src_bank,
    input logic                         mem_en,
    input logic                         mem_we,
    input logic [BANK_BITS-1:0]         mem_bank,
    input logic                         rd_valid
);
    // R1: nothing is granted while reset is held.
    always @(posedge clk) begin
        if (!rst_n) assert_no_grant_in_reset_R1: assert (src_gnt == '0 && !mem_en);
    end

    assert_single_grant_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(src_gnt));

    assert_bank_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_en |=> !(mem_en && mem_bank == $past(mem_bank)));

    // R3: a lower source may only win over a requesting higher one when
    // that higher one's bank was taken last cycle.
    for (genvar k = 1; k < NUM_SRC; k++) begin : g_k
        for (genvar j = 0; j < k; j++) begin : g_j
            assert_priority_R3: assert property (@(posedge clk) disable iff (!rst_n)
                (src_gnt[k] && src_req[j]) |->
                ($past(mem_en) && $past(mem_bank) == src_bank[j*BANK_BITS +: BANK_BITS]));
        end
    end

    assert_read_return_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_en && !mem_we) |=> ##1 rd_valid);

    assert_return_origin_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> ($past(mem_en, 2) && !$past(mem_we, 2)));
endmodule

bind membank_arbiter membank_arbiter_chk #(.BANK_BITS(BANK_BITS)) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_req  (src_req),
    .src_gnt  (src_gnt),
    .src_bank (src_bank),
    .mem_en   (mem_en),
    .mem_we   (mem_we),
    .mem_bank (mem_addr[BANK_LSB +: BANK_BITS]),
    .rd_valid (rd_valid)
);

// File: tb/membank_arbiter_tb_top.sv
`timescale 1ns/1ps
// Sweep bench: every request mask x bank combination after each busy state.
module membank_arbiter_tb_top;
    localparam int AW = 16, DW = 32, BB = 2, BL = 4, NS = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic [NS-1:0]  src_req = '0, src_we = '0;
    logic [NS*AW-1:0] src_addr = '0;
    logic [NS*DW-1:0] src_wdata = '0;
    logic [NS-1:0]  src_gnt, src_stall;
    logic           mem_en, mem_we, rd_valid;
    logic [AW-1:0]  mem_addr;
    logic [DW-1:0]  mem_wdata, mem_rdata = '0, rd_data;
    logic [1:0]     rd_src;

    int checks = 0, failures = 0, cyc = 0;
    bit done = 0;

    // bench reference state
    bit m_busy_v = 0; int m_busy_b = 0;
    bit p1_v = 0, p2_v = 0; int p1_s = 0, p2_s = 0;

    always #5 clk = ~clk;

    membank_arbiter #(.ADDR_W(AW), .DATA_W(DW), .BANK_BITS(BB), .BANK_LSB(BL)) dut_i (
        .clk(clk), .rst_n(rst_n), .src_req(src_req), .src_we(src_we),
        .src_addr(src_addr), .src_wdata(src_wdata), .src_gnt(src_gnt),
        .src_stall(src_stall), .mem_en(mem_en), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
        .rd_valid(rd_valid), .rd_src(rd_src), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%0h exp=%0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // One cycle: drive, predict, compare, then advance the reference state.
    task automatic run_cycle(input logic [3:0] req, input logic [3:0] we, input logic [7:0] banks);
        int win;
        logic [3:0] exp_gnt;
        @(negedge clk);
        cyc++;
        for (int i = 0; i < NS; i++) begin
            logic [AW-1:0] a;
            a = AW'(cyc * 37 + i * 1111);
            a[BL +: BB] = banks[i*2 +: 2];       // R5: bank field at [5:4]
            src_addr[i*AW +: AW]  = a;
            src_wdata[i*DW +: DW] = DW'(cyc * 7919 + i * 104729);
        end
        src_req = req; src_we = we;
        mem_rdata = DW'(cyc * 48271 + 5);
        #2;
        win = -1;
        for (int i = 0; i < NS; i++)
            if (win < 0 && req[i] && !(m_busy_v && int'(banks[i*2 +: 2]) == m_busy_b)) win = i;
        exp_gnt = (win >= 0) ? (4'b1 << win) : 4'b0;
        chk($countones(src_gnt) <= 1, "R2 onehot", src_gnt, exp_gnt);
        chk(src_gnt == exp_gnt, "R3/R4 grant", src_gnt, exp_gnt);
        chk(src_stall == (req & ~exp_gnt), "R6 stall", src_stall, req & ~exp_gnt);
        chk(mem_en == (win >= 0), "R2 mem_en", mem_en, win >= 0);
        if (win >= 0) begin
            chk(mem_we == we[win], "R7 we", mem_we, we[win]);
            chk(mem_addr == src_addr[win*AW +: AW], "R7 addr", mem_addr, src_addr[win*AW +: AW]);
            chk(mem_wdata == src_wdata[win*DW +: DW], "R7 wdata", mem_wdata, src_wdata[win*DW +: DW]);
        end
        chk(rd_valid == p2_v, "R8 rd_valid", rd_valid, p2_v);
        if (p2_v) begin
            chk(int'(rd_src) == p2_s, "R8 rd_src", rd_src, p2_s);
            chk(rd_data == mem_rdata, "R8 rd_data", rd_data, mem_rdata);
        end
        @(posedge clk);
        p2_v = p1_v; p2_s = p1_s;
        p1_v = (win >= 0) && !we[win]; p1_s = (win < 0) ? 0 : win;
        m_busy_v = (win >= 0);
        m_busy_b = (win >= 0) ? int'(banks[win*2 +: 2]) : 0;
    endtask

    initial begin
        // R1: requests during reset are ignored
        src_req = 4'hF;
        repeat (3) begin
            @(negedge clk);
            chk(src_gnt == 4'h0 && !mem_en, "R1 reset grant", src_gnt, 0);
            chk(!rd_valid, "R1 reset rd_valid", rd_valid, 0);
        end
        @(negedge clk); rst_n = 1'b1; src_req = '0;
        // R1: all banks free right after reset
        run_cycle(4'hF, 4'h0, 8'h00);
        // R4: same source hammering one bank is granted every other cycle
        for (int n = 0; n < 8; n++) run_cycle(4'b0100, 4'h0, 8'h55);
        // R3/R4/R5/R6/R7/R8 sweep: previous busy bank x mask x banks
        for (int bs = 0; bs < 5; bs++)
            for (int mask = 0; mask < 16; mask++)
                for (int bk = 0; bk < 256; bk++) begin
                    if (bs < 4) run_cycle(4'b0001, 4'h0, {4{2'(bs)}});
                    else        run_cycle(4'b0000, 4'h0, 8'h00);
                    run_cycle(4'(mask), 4'(bk ^ mask ^ bs), 8'(bk));
                end
        run_cycle(4'h0, 4'h0, 8'h00);
        run_cycle(4'h0, 4'h0, 8'h00);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #1_500_000;
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired at cycle %0d", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule